// File: doc/BRIEF.md
# Packed BCD Digit-Sum Reduction Tree

This block adds up all the decimal digits of one packed-BCD word and returns the total, itself in packed BCD. Each digit sits in its own 4-bit field, so clearing a digit is a bit mask and moving a digit is a 4-bit shift. The sum is built as a fully unrolled tree of width-doubling lanes. At the first level, adjacent digits are added into 2-digit lanes. At the next level, adjacent 2-digit lanes are added into 4-digit lanes. The tree continues this way until one lane spans the whole word. The tree therefore has log2(digit count) levels.

Every level is one full-width decimal adder split into independent lanes. Within a lane, a nibble whose raw sum exceeds 9 is corrected by adding 6, and a carry moves only between the nibbles of that lane. The tree's masks and shift distances are fixed when the design is built. A parameter picks a word of 8 digits or 16 digits. A second parameter places a register after the tree or leaves the path purely combinational.

Top module: `bcd_digit_sum`

## Requirements
- R1: `sum_out` equals the decimal sum of all digits of `word_in`, in packed BCD with the units digit in bits [3:0], the tens digit in bits [7:4] and the hundreds digit in bits [11:8].
- R2: `sum_out` is 2 BCD digits wide when `DIGITS`=8 and 3 BCD digits wide when `DIGITS`=16. Any unused high digit of the total reads as zero.
- R3: Every digit of `sum_out` lies in 0..9 whenever every input digit lies in 0..9.
- R4: A lane carry never crosses a lane boundary. An all-nines word gives 72 for 8 digits and 144 for 16 digits.
- R5: An all-zero word gives a sum of 0.
- R6: With `OUT_REG`=1, `sum_out` and `sum_valid` follow one clock after `word_valid`, and `sum_valid` is low one clock after `word_valid` was low.
- R7: With `OUT_REG`=1, a cycle with `rst` high makes `sum_valid` low at the next clock, even when `word_valid` is high.
- R8: With `OUT_REG`=0, `sum_out` and `sum_valid` follow `word_in` and `word_valid` within the same cycle.
- R9: A word with a single nonzero digit d gives d, whatever the position of that digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset; clears `sum_valid` |
| word_valid | input | 1 | Marks `word_in` as carrying a word |
| word_in | input | 4*DIGITS | Packed-BCD word, digit 0 in bits [3:0] |
| sum_valid | output | 1 | Marks `sum_out` as carrying a result |
| sum_out | output | 4*SUM_DIGITS | Packed-BCD digit total (2 digits for 8, 3 digits for 16) |

## Verification
The bench builds three instances side by side. The first has 8 digits with the output register. The second has 16 digits with the output register. The third has 8 digits and is purely combinational. The 16-digit build adds a fourth tree level and a hundreds digit in the output, which makes the 144 total and a carry into a third digit reachable. The combinational build exposes the same-cycle path, and the two registered builds cover one-clock latency and reset. All three are fed the same lower digits, so one stimulus checks the 3-level and 4-level trees against the same digit-by-digit reference.

// File: rtl/bcd_sum_pkg.sv
package bcd_sum_pkg;

  // Number of decimal digits needed to hold 9 * n_digits.
  function automatic int sum_digits(input int n_digits);
    int m;
    int d;
    m = 9 * n_digits;
    d = 0;
    while (m > 0) begin
      m = m / 10;
      d = d + 1;
    end
    return d;
  endfunction

  // Binary value of a 12-bit packed BCD number.
  function automatic int bcd3_value(input logic [11:0] v);
    return 100 * int'(v[11:8]) + 10 * int'(v[7:4]) + int'(v[3:0]);
  endfunction

endpackage

// File: rtl/bcd_lane_add.sv
module bcd_lane_add #(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout
);

  logic [DIGITS:0] carry;
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_nib
    logic [4:0] raw;
    logic [3:0] dig;
    logic       co;
    always_comb begin
      raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, carry[g]};
      if (raw > 5'd9) begin
        dig = 4'(raw + 5'd6);
        co  = 1'b1;
      end else begin
        dig = raw[3:0];
        co  = 1'b0;
      end
      // R3: decimal correction keeps each nibble a legal digit
      if (a[4*g +: 4] <= 4'd9 && b[4*g +: 4] <= 4'd9)
        a_r3_digit_legal: assert (dig <= 4'd9);
    end
    assign sum[4*g +: 4] = dig;
    assign carry[g+1]    = co;
  end

  assign cout = carry[DIGITS];

endmodule

// File: rtl/bcd_tree_level.sv
module bcd_tree_level #(
  parameter int DIGITS  = 8,
  parameter int LANE_IN = 1
) (
  input  logic [4*DIGITS-1:0] d,
  output logic [4*DIGITS-1:0] q
);

  localparam int LANE_OUT = 2 * LANE_IN;
  localparam int N_LANES  = DIGITS / LANE_OUT;
  localparam int W_IN     = 4 * LANE_IN;
  localparam int W_OUT    = 4 * LANE_OUT;

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    logic [W_OUT-1:0] keep_lo;
    logic [W_OUT-1:0] keep_hi;
    logic             lane_co;

    // Masked low half, and high half shifted down by one input lane.
    assign keep_lo = {{W_IN{1'b0}}, d[j*W_OUT +: W_IN]};
    assign keep_hi = {{W_IN{1'b0}}, d[j*W_OUT + W_IN +: W_IN]};

    bcd_lane_add #(.DIGITS(LANE_OUT)) u_add (
      .a   (keep_lo),
      .b   (keep_hi),
      .sum (q[j*W_OUT +: W_OUT]),
      .cout(lane_co)
    );

    // R4: a lane's total always fits the lane, so nothing spills over
    always_comb begin
      if (keep_lo <= {W_OUT{1'b1}} && lane_co !== 1'bx)
        a_r4_no_lane_carry: assert (lane_co == 1'b0);
    end
  end

endmodule

// File: rtl/bcd_digit_sum.sv
module bcd_digit_sum
  import bcd_sum_pkg::*;
#(
  parameter int DIGITS  = 8,
  parameter bit OUT_REG = 1'b1,
  parameter int SUM_DIGITS = sum_digits(DIGITS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    word_valid,
  input  logic [4*DIGITS-1:0]     word_in,
  output logic                    sum_valid,
  output logic [4*SUM_DIGITS-1:0] sum_out
);

  localparam int LEVELS = $clog2(DIGITS);
  localparam int W      = 4 * DIGITS;
  localparam int SW     = 4 * SUM_DIGITS;

  logic [W-1:0] stage [0:LEVELS];
  assign stage[0] = word_in;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    bcd_tree_level #(
      .DIGITS (DIGITS),
      .LANE_IN(1 << l)
    ) u_level (
      .d(stage[l]),
      .q(stage[l+1])
    );
  end

  logic [SW-1:0] total;
  assign total = stage[LEVELS][SW-1:0];

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) sum_valid <= 1'b0;
      else     sum_valid <= word_valid;
      sum_out <= total;
    end

    // R6: valid follows one clock later
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> sum_valid);
    a_r6_idle_latency: assert property (@(posedge clk) disable iff (rst)
      !word_valid |=> !sum_valid);
  end else begin : g_comb
    assign sum_valid = word_valid;
    assign sum_out   = total;
  end

  // R2: digits above the output width stay zero at the tree's root
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> stage[LEVELS][W-1:SW] == '0);

  // R1: total never exceeds nine times the digit count
  a_r1_bound: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> bcd3_value(12'(sum_out)) <= 9 * DIGITS);

endmodule

// File: tb/bcd_digit_sum_test.sv
module bcd_digit_sum_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [63:0] w16 = '0;

  logic        v8, v16, vc;
  logic [7:0]  s8, sc;
  logic [11:0] s16;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bcd_digit_sum #(.DIGITS(8), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst(rst), .word_valid(vld), .word_in(w16[31:0]),
    .sum_valid(v8), .sum_out(s8));

  bcd_digit_sum #(.DIGITS(16), .OUT_REG(1'b1)) uut16 (
    .clk(clk), .rst(rst), .word_valid(vld), .word_in(w16),
    .sum_valid(v16), .sum_out(s16));

  bcd_digit_sum #(.DIGITS(8), .OUT_REG(1'b0)) uutc (
    .clk(clk), .rst(rst), .word_valid(vld), .word_in(w16[31:0]),
    .sum_valid(vc), .sum_out(sc));

  function automatic logic [11:0] ref_sum(input logic [63:0] w, input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += int'(w[4*i +: 4]);
    return {4'(s / 100), 4'((s / 10) % 10), 4'(s % 10)};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one word at a negedge, check the comb path, then the registered one.
  task automatic apply(input logic [63:0] w, input string req);
    logic [11:0] e8, e16;
    @(negedge clk);
    w16 = w;
    vld = 1'b1;
    e8  = ref_sum(w, 8);
    e16 = ref_sum(w, 16);
    #1;
    check({req, " R8 comb"}, {4'h0, sc}, e8);
    check({req, " R8 comb valid"}, {11'h0, vc}, 12'h1);
    @(negedge clk);
    check({req, " R1 8-digit"}, {4'h0, s8}, e8);
    check({req, " R1 16-digit"}, s16, e16);
    check({req, " R6 valid"}, {10'h0, v8, v16}, 12'h3);
    for (int i = 0; i < 3; i++)
      if (s16[4*i +: 4] > 4'd9) check({req, " R3 digit"}, {8'h0, s16[4*i +: 4]}, 12'h9);
    vld = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R7 reset 8", {11'h0, v8}, 12'h0);
    check("R7 reset 16", {11'h0, v16}, 12'h0);
    vld = 1'b1;
    @(negedge clk);
    check("R7 reset with valid high", {10'h0, v8, v16}, 12'h0);
    vld = 1'b0;
    rst = 1'b0;
  endtask

  task automatic t_example;
    apply(64'h0000_0000_1234_5678, "R1 example");
    check("R2 8-digit width", 12'($bits(s8)), 12'd8);
    check("R2 16-digit width", 12'($bits(s16)), 12'd12);
  endtask

  task automatic t_zero;
    apply(64'h0, "R5 zero");
  endtask

  task automatic t_nines;
    apply({16{4'h9}}, "R4 all nines");
    check("R4 8-digit 72", {4'h0, s8}, 12'h072);
    check("R4 16-digit 144", s16, 12'h144);
  endtask

  task automatic t_single;
    for (int p = 0; p < 16; p++) begin
      logic [63:0] w;
      w = '0;
      w[4*p +: 4] = 4'(1 + p % 9);
      apply(w, "R9 single digit");
    end
  endtask

  task automatic t_random;
    for (int k = 0; k < 40; k++) begin
      logic [63:0] w;
      for (int i = 0; i < 16; i++) w[4*i +: 4] = 4'($urandom_range(9, 0));
      apply(w, "R3 random");
    end
  endtask

  task automatic t_idle;
    apply(64'h0000_0000_9999_0001, "R6 before gap");
    @(negedge clk);
    check("R6 valid drops", {10'h0, v8, v16}, 12'h0);
    check("R8 comb valid drops", {11'h0, vc}, 12'h0);
  endtask

  task automatic t_midreset;
    @(negedge clk);
    w16 = 64'h1;
    vld = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-run reset", {10'h0, v8, v16}, 12'h0);
    rst = 1'b0;
    vld = 1'b0;
  endtask

  initial begin
    t_reset();
    t_example();
    t_zero();
    t_nines();
    t_single();
    t_random();
    t_idle();
    t_midreset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule